// File: doc/BRIEF.md
# Biphase-coded serial receiver with sync hunt

This block takes a single serial line carrying biphase-space (FM0) or biphase-mark (FM1) coding and samples it with a clock that runs at a fixed multiple of the bit rate. The default multiple is 16. The block times the intervals between line transitions and sorts each transition into a mid-cell edge, a cell-boundary edge or a coding violation. From those edges it rebuilds the data bits.

Decoded bits pass through a 12-bit history register. This register serves two purposes: it searches for a programmable sync pattern, and it assembles output words. Word framing is gated by a sticky sync flag. Until the pattern has been seen, the block stays in hunt mode and produces no words.

A debug input can bypass the gate so that words are framed before sync is found. A clear input drops the sync flag and sends the block back to hunt mode.

Top module: `fmrx_top`

## Requirements
- R1: Decoded bits are packed into 12-bit words with the earliest bit in bit 11. Each completed word is written to `word_out` together with a `word_valid` pulse that lasts exactly one clock cycle.
- R2: When `sync_locked` is 0 and `allow_presync` is 0, no `word_valid` pulse is produced, whatever the line carries.
- R3: When the 12 most recent decoded bits (earliest in bit 11) equal `sync_pattern`, `sync_locked` is set and the word counter restarts. The matching bit counts as bit 1 of the first word, so the first word holds that bit in bit 11 followed by the next 11 bits.
- R4: When `allow_presync` is 1 and `clear_sync` is 0, words are framed every 12 bits even though `sync_locked` is 0. Counting starts at the first bit of a burst that follows an idle line.
- R5: While `clear_sync` is 1, `sync_locked` reads 0 on the following cycle, the word counter is held at zero and no word is produced. This applies in the pre-sync mode as well. A 0-1-0 pulse on `clear_sync` returns the block to hunt mode.
- R6: With `fm_mark`=0 (FM0), every cell starts with a transition. A cell that also has a mid-cell transition decodes as 0, and a cell without one decodes as 1.
- R7: With `fm_mark`=1 (FM1), a cell with a mid-cell transition decodes as 1, and a cell without one decodes as 0.
- R8: Decoding is correct when the first half-cell lasts 7 to 9 samples and the whole cell lasts 15 to 17 samples, at 16 samples per nominal bit.
- R9: A transition that falls outside both the mid-cell window (6 to 10 samples) and the boundary window (15 to 17 samples) is a coding violation. It clears the word counter, leaves `sync_locked` unchanged, and is taken as a new cell boundary.
- R10: A line with no transition for more than two bit times clears the word counter and leaves `sync_locked` unchanged.
- R11: After reset, `word_out` is 0, `word_valid` is 0 and `sync_locked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 16 cycles per nominal bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Coded serial line; synchronised internally |
| fm_mark | input | 1 | 0 selects FM0 (space), 1 selects FM1 (mark) |
| allow_presync | input | 1 | Frames words before sync when set |
| clear_sync | input | 1 | Clears the sync flag and word counter while high |
| sync_pattern | input | 12 | Sync pattern, earliest bit in bit 11 |
| word_out | output | 12 | Last completed word |
| word_valid | output | 1 | One-cycle pulse when `word_out` is updated |
| sync_locked | output | 1 | Sticky sync-found flag |

## Verification
The assertions assume that `line_in` holds each level for several samples, so a new word can never complete one cycle after the previous one. They also assume that `sync_pattern` and `fm_mark` do not change while a burst is being received.

The stimulus changes the line only at falling clock edges. It spaces transitions according to the half-cell and cell lengths of each scenario, and it leaves more than two bit times of idle line between scenarios. It changes control inputs only while the line is idle.

// File: rtl/fmrx_pkg.sv
package fmrx_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_HALF = 2'd1,
    EV_FULL = 2'd2,
    EV_BAD  = 2'd3
  } edge_kind_e;

  // percentage of a sample count, rounded up or down
  function automatic int pct_up(input int n, input int p);
    return (n * p + 99) / 100;
  endfunction

  function automatic int pct_dn(input int n, input int p);
    return (n * p) / 100;
  endfunction

  // sort a transition by the number of samples since the previous one
  function automatic edge_kind_e classify(input int iv, input int ovs);
    if (iv >= pct_up(ovs, 35) && iv <= pct_dn(ovs, 65))
      return EV_HALF;
    else if (iv >= pct_up(ovs, 90) && iv <= pct_dn(ovs, 110))
      return EV_FULL;
    else
      return EV_BAD;
  endfunction

  // data value of a cell from its mid-cell transition and the coding mode
  function automatic logic cell_value(input logic has_mid, input logic mark);
    return mark ? has_mid : ~has_mid;
  endfunction

endpackage

// File: rtl/fmrx_edge_timer.sv
module fmrx_edge_timer
  import fmrx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  output edge_kind_e edge_kind,
  output logic       timeout
);
  localparam int LIM  = 2 * OVS + 1;
  localparam int CW   = $clog2(LIM + 1);

  logic          s1, s2, prev;
  logic [CW-1:0] cnt;
  logic          trans;

  assign trans = s2 ^ prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
      cnt  <= CW'(LIM);
    end else begin
      s1   <= line_in;
      s2   <= s1;
      prev <= s2;
      if (trans)
        cnt <= CW'(1);
      else if (cnt != CW'(LIM))
        cnt <= cnt + 1'b1;
    end
  end

  assign timeout   = !trans && (cnt == CW'(2 * OVS));
  assign edge_kind = trans ? classify(int'(cnt), OVS) : EV_NONE;

endmodule

// File: rtl/fmrx_fm_decoder.sv
module fmrx_fm_decoder
  import fmrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  edge_kind_e edge_kind,
  input  logic       timeout,
  input  logic       fm_mark,
  output logic       bit_valid,
  output logic       bit_data,
  output logic       viol
);
  logic half_seen;
  logic has_mid;

  always_comb begin
    bit_valid = 1'b0;
    viol      = 1'b0;
    has_mid   = 1'b0;
    case (edge_kind)
      EV_HALF: begin
        if (half_seen) begin
          bit_valid = 1'b1;
          has_mid   = 1'b1;
        end
      end
      EV_FULL: begin
        if (half_seen) viol = 1'b1;
        else           bit_valid = 1'b1;
      end
      EV_BAD:  viol = 1'b1;
      default: ;
    endcase
  end

  assign bit_data = cell_value(has_mid, fm_mark);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      half_seen <= 1'b0;
    else if (timeout || viol || edge_kind == EV_FULL)
      half_seen <= 1'b0;
    else if (edge_kind == EV_HALF)
      half_seen <= ~half_seen;
  end

endmodule

// File: rtl/fmrx_framer.sv
module fmrx_framer #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_data,
  input  logic              viol,
  input  logic              timeout,
  input  logic              clear_sync,
  input  logic              allow_presync,
  input  logic [WORD_W-1:0] sync_pattern,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              sync_locked,
  output logic              sync_match
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] hist, hist_nx;
  logic [CNT_W-1:0]  wcnt;
  logic              framing_en;

  assign hist_nx    = {hist[WORD_W-2:0], bit_data};
  assign sync_match = bit_valid && (hist_nx == sync_pattern);
  assign framing_en = !clear_sync && (sync_locked || allow_presync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist        <= '0;
      wcnt        <= '0;
      word_out    <= '0;
      word_valid  <= 1'b0;
      sync_locked <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (bit_valid) hist <= hist_nx;

      if (clear_sync)      sync_locked <= 1'b0;
      else if (sync_match) sync_locked <= 1'b1;

      if (clear_sync || viol || timeout) begin
        wcnt <= '0;
      end else if (sync_match) begin
        wcnt <= CNT_W'(1);
      end else if (bit_valid && framing_en) begin
        if (wcnt == CNT_W'(WORD_W - 1)) begin
          wcnt       <= '0;
          word_out   <= hist_nx;
          word_valid <= 1'b1;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fmrx_top.sv
module fmrx_top
  import fmrx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              fm_mark,
  input  logic              allow_presync,
  input  logic              clear_sync,
  input  logic [WORD_W-1:0] sync_pattern,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              sync_locked
);
  edge_kind_e edge_kind;
  logic       timeout;
  logic       bit_valid;
  logic       bit_data;
  logic       viol;
  logic       sync_match;

  fmrx_edge_timer #(.OVS(OVS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .edge_kind (edge_kind),
    .timeout   (timeout)
  );

  fmrx_fm_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_kind (edge_kind),
    .timeout   (timeout),
    .fm_mark   (fm_mark),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .viol      (viol)
  );

  fmrx_framer #(.WORD_W(WORD_W)) u_frm (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_valid     (bit_valid),
    .bit_data      (bit_data),
    .viol          (viol),
    .timeout       (timeout),
    .clear_sync    (clear_sync),
    .allow_presync (allow_presync),
    .sync_pattern  (sync_pattern),
    .word_out      (word_out),
    .word_valid    (word_valid),
    .sync_locked   (sync_locked),
    .sync_match    (sync_match)
  );

endmodule

// File: rtl/fmrx_chk.sv
module fmrx_chk (
  input logic clk,
  input logic rst_n,
  input logic clear_sync,
  input logic allow_presync,
  input logic word_valid,
  input logic sync_locked,
  input logic bit_valid,
  input logic viol,
  input logic timeout,
  input logic sync_match
);
  // R1
  wv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R2
  hunt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(!clear_sync && (sync_locked || allow_presync)));

  // R3
  lock_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_locked) |-> $past(sync_match));

  // R5
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_sync |=> (!sync_locked && !word_valid));

  // R6
  bit_or_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && viol));

  // R9
  viol_keep_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !clear_sync) |=> $stable(sync_locked));

  // R10
  idle_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout || viol) |=> !word_valid);

endmodule

bind fmrx_top fmrx_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clear_sync    (clear_sync),
  .allow_presync (allow_presync),
  .word_valid    (word_valid),
  .sync_locked   (sync_locked),
  .bit_valid     (bit_valid),
  .viol          (viol),
  .timeout       (timeout),
  .sync_match    (sync_match)
);

// File: tb/test_fmrx_top.sv
module test_fmrx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_in = 1'b0;
  logic        fm_mark = 1'b0;
  logic        allow_presync = 1'b0;
  logic        clear_sync = 1'b0;
  logic [11:0] sync_pattern = 12'hB47;
  logic [11:0] word_out;
  logic        word_valid;
  logic        sync_locked;

  int n_chk = 0;
  int n_fail = 0;
  int ngot = 0;
  logic [11:0] got [8];
  int h_len = 8;
  int c_len = 16;

  always #2.5 clk = ~clk;

  fmrx_top i_fmrx_top (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .fm_mark(fm_mark),
    .allow_presync(allow_presync), .clear_sync(clear_sync),
    .sync_pattern(sync_pattern), .word_out(word_out),
    .word_valid(word_valid), .sync_locked(sync_locked)
  );

  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      if (ngot < 8) got[ngot] = word_out;
      ngot = ngot + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic toggle();
    line_in = ~line_in;
  endtask

  // send n bits of v, most significant first, with the current cell timing
  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      logic mid;
      mid = fm_mark ? v[i] : ~v[i];
      toggle();
      if (mid) begin
        wait_n(h_len);
        toggle();
        wait_n(c_len - h_len);
      end else begin
        wait_n(c_len);
      end
    end
  endtask

  task automatic end_burst();
    toggle();
    wait_n(60);
  endtask

  task automatic pulse_clear();
    clear_sync = 1'b1;
    wait_n(2);
    clear_sync = 1'b0;
    wait_n(2);
  endtask

  task automatic t_reset();
    chk("R11 word_out", 32'(word_out), 32'h0);
    chk("R11 word_valid", 32'(word_valid), 32'h0);
    chk("R11 sync_locked", 32'(sync_locked), 32'h0);
  endtask

  // hunt: preamble of zeros, the sync pattern, then two data words
  task automatic t_hunt(input logic mk, input int h, input int c, input string req);
    pulse_clear();
    fm_mark = mk; h_len = h; c_len = c;
    ngot = 0;
    send_bits(64'h0, 16);
    chk({req, " R2 no word before sync"}, 32'(ngot), 32'd0);
    chk({req, " R2 not locked in preamble"}, 32'(sync_locked), 32'd0);
    send_bits(64'(sync_pattern >> 1), 11);
    send_bits(64'hFFF, 12);   // bit 11 is the matched bit (pattern bit 0 = 1)
    send_bits(64'h000, 12);
    end_burst();
    chk({req, " R3 locked"}, 32'(sync_locked), 32'd1);
    chk({req, " R1 word count"}, 32'(ngot), 32'd2);
    chk({req, " R3 first word"}, 32'(got[0]), 32'hFFF);
    chk({req, " R1 second word"}, 32'(got[1]), 32'h000);
    h_len = 8; c_len = 16;
  endtask

  // R9: glitch while locked; the glitch becomes a boundary, adding one '1'
  task automatic t_violation();
    ngot = 0;
    send_bits(64'h2A, 6);
    toggle(); wait_n(3);
    toggle(); wait_n(16);
    send_bits(64'b00110011001100110011001, 23);
    end_burst();
    chk("R9 sync kept", 32'(sync_locked), 32'd1);
    chk("R9 word count", 32'(ngot), 32'd2);
    chk("R9 word after violation", 32'(got[0]), 32'h999);
    chk("R9 second word", 32'(got[1]), 32'h999);
  endtask

  // R10: partial word then a long idle line
  task automatic t_timeout();
    ngot = 0;
    send_bits(64'h15, 5);
    end_burst();
    chk("R10 no word from partial", 32'(ngot), 32'd0);
    send_bits(64'h333333, 24);
    end_burst();
    chk("R10 sync kept", 32'(sync_locked), 32'd1);
    chk("R10 word count", 32'(ngot), 32'd2);
    chk("R10 word aligned to burst", 32'(got[0]), 32'h333);
  endtask

  task automatic t_clear();
    pulse_clear();
    chk("R5 sync cleared", 32'(sync_locked), 32'd0);
    ngot = 0;
    send_bits(64'h333333, 24);
    end_burst();
    chk("R5 hunt again: no words", 32'(ngot), 32'd0);
  endtask

  task automatic t_presync();
    allow_presync = 1'b1;
    ngot = 0;
    send_bits(64'h333666, 24);
    end_burst();
    chk("R4 word count", 32'(ngot), 32'd2);
    chk("R4 first word", 32'(got[0]), 32'h333);
    chk("R4 second word", 32'(got[1]), 32'h666);
    chk("R4 still unlocked", 32'(sync_locked), 32'd0);
    ngot = 0;
    clear_sync = 1'b1;
    send_bits(64'h333333, 24);
    end_burst();
    clear_sync = 1'b0;
    chk("R5 clear held blocks pre-sync words", 32'(ngot), 32'd0);
    allow_presync = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_n(5);
    t_reset();
    rst_n = 1'b1;
    wait_n(5);
    t_reset();
    t_hunt(1'b0, 8, 16, "R6 FM0");
    t_violation();
    t_timeout();
    t_hunt(1'b0, 7, 15, "R8 short");
    t_hunt(1'b0, 9, 17, "R8 long");
    t_hunt(1'b1, 8, 16, "R7 FM1");
    t_hunt(1'b1, 9, 17, "R7 R8 FM1 long");
    t_clear();
    t_presync();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule